// File: doc/BRIEF.md
# Serial Converter Frame and Power-Mode Front End

This block is the device-side digital front end of a 12-bit sampling converter. It watches an active-low chip select and a serial clock, both sampled through a system clock. It drives a serial data pin with a separate output-enable that models high impedance. It also tracks whether the converter is in its normal or its shutdown power mode. A parallel 12-bit sample input stands in for the analog result. The block holds that value when a frame begins and shifts it out. The result is framed by three leading zeros and one trailing zero.

Serial clock edges are counted from the chip-select falling edge. The sampler goes back to tracking on a fixed rising edge. The data pin turns off at the end of the frame, or earlier if chip select is released. The falling-edge count reached when chip select rises sets the next power mode: the rise can be ignored, can force shutdown, or can keep the device powered while the word is cut short. A frame that begins in shutdown wakes the device. Its result is flagged invalid.

Top module: `adc_serial_front`

## Requirements
- R1: After reset the data output is disabled (`sdataEn`=0, `sdataOut`=0), `tracking`=1, `resultValid`=0, and `modeNormal` equals the `RESET_NORMAL` parameter (default 1, normal mode).
- R2: A chip-select falling edge enables the data output and drops `tracking` to 0 (hold).
- R3: `tracking` stays 0 through the 12th rising serial-clock edge of a frame and returns to 1 on the 13th.
- R4: Serial bit k, where k is the number of serial-clock falling edges since chip select fell (0..15), is 0 for k<3, is sample bit (14−k) for 3≤k≤14 (straight binary, MSB first), and is 0 for k=15. The sample is the value captured at the chip-select falling edge, and later changes to `sampleIn` have no effect on it.
- R5: The output is disabled at the 16th falling edge. It stays disabled for any further serial clocks while chip select remains low.
- R6: A chip-select rise after fewer than 2 falling edges disables the output and leaves the power mode unchanged.
- R7: In normal mode, a chip-select rise after 2 to 9 falling edges aborts the frame and enters shutdown (`modeNormal`=0).
- R8: A chip-select rise after 10 to 15 falling edges truncates the word, disables the output, and keeps normal mode.
- R9: `resultValid` is 1 for a frame that begins in normal mode. It is 0 for a frame that begins in shutdown. A wake-up frame that reaches its 10th falling edge restores normal mode, so the next frame is valid.
- R10: A wake-up frame whose chip select rises before its 10th falling edge returns the device to shutdown.
- R11: A serial-clock falling edge seen in the same system cycle as a chip-select rise is counted before the power-mode decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both serial inputs |
| rst | input | 1 | Synchronous active-high reset |
| csN | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, idles high |
| sampleIn | input | DATA_W | Parallel conversion result (12 bits by default) |
| sdataOut | output | 1 | Serial data bit, 0 while disabled |
| sdataEn | output | 1 | Output enable; 0 models high impedance |
| tracking | output | 1 | 1 while the sampler tracks, 0 while it holds |
| modeNormal | output | 1 | 1 in normal mode, 0 in shutdown or during wake-up |
| resultValid | output | 1 | Validity of the frame most recently started |

## Verification
A chip-select rise and a counted serial-clock falling edge can reach the control logic in the same system cycle. The power-mode decision then depends on whether that edge is counted first. The bench provokes this by changing both inputs in one timestep, which gives them equal synchronizer latency. It does this once on the 10th falling edge, where the device must stay in normal mode, and once on the 2nd, where it must shut down. Each case is judged by `modeNormal` after the frame and by `resultValid` on the frame that follows.

// File: rtl/adc_front_pkg.sv
package adc_front_pkg;

  typedef enum logic [1:0] {
    PM_SHUT = 2'd0,
    PM_WAKE = 2'd1,
    PM_NORM = 2'd2
  } pwrMode_e;

  typedef struct packed {
    logic load;     // capture sample, enable output
    logic shift;    // advance to the next serial bit
    logic release_; // disable output
  } dpStrobe_t;

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rawIn,
  output logic [W-1:0] riseOut,
  output logic [W-1:0] fallOut
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta, stable, prior;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta   <= RST_VAL[i];
        stable <= RST_VAL[i];
        prior  <= RST_VAL[i];
      end else begin
        meta   <= rawIn[i];
        stable <= meta;
        prior  <= stable;
      end
    end
    assign riseOut[i] = stable & ~prior;
    assign fallOut[i] = ~stable & prior;
  end

endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import adc_front_pkg::*;
#(
  parameter int FRAME_FALLS  = 16,
  parameter int TRACK_RISE   = 13,
  parameter int SHUT_LO      = 2,
  parameter int SHUT_HI      = 10,
  parameter bit RESET_NORMAL = 1'b1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      csFall,
  input  logic      csRise,
  input  logic      sclkFall,
  input  logic      sclkRise,
  output dpStrobe_t strb,
  output logic      tracking,
  output logic      modeNormal,
  output logic      frameValid
);

  localparam int CNT_W  = $clog2(FRAME_FALLS + 1);
  localparam int RISE_W = $clog2(TRACK_RISE + 1);
  localparam logic [CNT_W-1:0]  FALL_END = CNT_W'(FRAME_FALLS);
  localparam logic [CNT_W-1:0]  LO_CNT   = CNT_W'(SHUT_LO);
  localparam logic [CNT_W-1:0]  HI_CNT   = CNT_W'(SHUT_HI);
  localparam logic [RISE_W-1:0] RISE_END = RISE_W'(TRACK_RISE);

  logic              active;
  logic [CNT_W-1:0]  fallCnt, fallNext;
  logic [RISE_W-1:0] riseCnt;
  pwrMode_e          mode, modeOnRise;
  logic              countFall, frameEnd;

  assign countFall = active && sclkFall && (fallCnt < FALL_END);
  assign fallNext  = fallCnt + CNT_W'(countFall);
  assign frameEnd  = countFall && (fallNext == FALL_END);

  assign strb.load     = csFall;
  assign strb.shift    = countFall && (fallNext < FALL_END);
  assign strb.release_ = active && (csRise || frameEnd);

  // Decision uses the count including a fall seen in this same cycle
  always_comb begin
    unique case (mode)
      PM_NORM: modeOnRise = (fallNext >= LO_CNT && fallNext < HI_CNT) ? PM_SHUT : PM_NORM;
      PM_WAKE: modeOnRise = (fallNext >= HI_CNT) ? PM_NORM : PM_SHUT;
      default: modeOnRise = PM_SHUT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      fallCnt    <= '0;
      riseCnt    <= '0;
      mode       <= RESET_NORMAL ? PM_NORM : PM_SHUT;
      tracking   <= 1'b1;
      frameValid <= 1'b0;
    end else if (csFall) begin
      active     <= 1'b1;
      fallCnt    <= '0;
      riseCnt    <= '0;
      tracking   <= 1'b0;
      frameValid <= (mode == PM_NORM);
      if (mode == PM_SHUT) mode <= PM_WAKE;
    end else if (active) begin
      fallCnt <= fallNext;
      if (sclkRise && riseCnt < RISE_END) begin
        riseCnt <= riseCnt + 1'b1;
        if (riseCnt == RISE_END - 1'b1) tracking <= 1'b1;
      end
      if (csRise) begin
        active   <= 1'b0;
        tracking <= 1'b1;
        mode     <= modeOnRise;
      end else begin
        if (mode == PM_WAKE && fallNext >= HI_CNT) mode <= PM_NORM;
        if (frameEnd) active <= 1'b0;
      end
    end
  end

  assign modeNormal = (mode == PM_NORM);

endmodule

// File: rtl/shift_out.sv
module shift_out
  import adc_front_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int LEAD_ZEROS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              sdataOut,
  output logic              sdataEn
);

  localparam int FRAME_BITS = LEAD_ZEROS + DATA_W + 1;

  logic [FRAME_BITS-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      sdataEn <= 1'b0;
    end else if (strb.load) begin
      shreg   <= {{LEAD_ZEROS{1'b0}}, sampleIn, 1'b0};
      sdataEn <= 1'b1;
    end else if (strb.release_) begin
      sdataEn <= 1'b0;
    end else if (strb.shift) begin
      shreg <= shreg << 1;
    end
  end

  assign sdataOut = sdataEn & shreg[FRAME_BITS-1];

endmodule

// File: rtl/adc_serial_front.sv
module adc_serial_front
  import adc_front_pkg::*;
#(
  parameter int DATA_W       = 12,
  parameter int LEAD_ZEROS   = 3,
  parameter int TRACK_RISE   = 13,
  parameter int SHUT_LO      = 2,
  parameter int SHUT_HI      = 10,
  parameter bit RESET_NORMAL = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csN,
  input  logic              sclk,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              sdataOut,
  output logic              sdataEn,
  output logic              tracking,
  output logic              modeNormal,
  output logic              resultValid
);

  localparam int FRAME_FALLS = LEAD_ZEROS + DATA_W + 1;

  logic [1:0] riseV, fallV;
  logic       csRiseS, csFallS, sclkRiseS, sclkFallS;
  dpStrobe_t  strb;

  edge_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst(rst), .rawIn({csN, sclk}),
    .riseOut(riseV), .fallOut(fallV)
  );

  assign csRiseS   = riseV[1];
  assign csFallS   = fallV[1];
  assign sclkRiseS = riseV[0];
  assign sclkFallS = fallV[0];

  frame_ctrl #(
    .FRAME_FALLS(FRAME_FALLS), .TRACK_RISE(TRACK_RISE),
    .SHUT_LO(SHUT_LO), .SHUT_HI(SHUT_HI), .RESET_NORMAL(RESET_NORMAL)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .csFall(csFallS), .csRise(csRiseS),
    .sclkFall(sclkFallS), .sclkRise(sclkRiseS),
    .strb(strb), .tracking(tracking),
    .modeNormal(modeNormal), .frameValid(resultValid)
  );

  shift_out #(.DATA_W(DATA_W), .LEAD_ZEROS(LEAD_ZEROS)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .sampleIn(sampleIn),
    .sdataOut(sdataOut), .sdataEn(sdataEn)
  );

endmodule

// File: rtl/adc_serial_front_chk.sv
module adc_serial_front_chk (
  input logic clk,
  input logic rst,
  input logic csFallS,
  input logic csRiseS,
  input logic sclkRiseS,
  input logic sdataEn,
  input logic tracking,
  input logic modeNormal,
  input logic resultValid
);

  AST_LOAD_HOLDS: assert property (@(posedge clk) disable iff (rst)
    csFallS |=> (sdataEn && !tracking)); // R2

  AST_RISE_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (csRiseS && sdataEn) |=> !sdataEn); // R6

  AST_SHUT_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $fell(modeNormal) |-> $past(csRiseS)); // R7

  AST_VALID_FOLLOWS_MODE: assert property (@(posedge clk) disable iff (rst)
    $rose(sdataEn) |-> (resultValid == $past(modeNormal))); // R9

  AST_TRACK_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(tracking) |-> $past(csRiseS || sclkRiseS)); // R3

endmodule

bind adc_serial_front adc_serial_front_chk u_chk (
  .clk(clk), .rst(rst), .csFallS(csFallS), .csRiseS(csRiseS),
  .sclkRiseS(sclkRiseS), .sdataEn(sdataEn), .tracking(tracking),
  .modeNormal(modeNormal), .resultValid(resultValid)
);

// File: tb/test_adc_serial_front.sv
module test_adc_serial_front;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csN = 1'b1;
  logic sclk = 1'b1;
  logic [11:0] sampleIn = '0;
  logic sdataOut, sdataEn, tracking, modeNormal, resultValid;
  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  adc_serial_front i_adc_serial_front (
    .clk(clk), .rst(rst), .csN(csN), .sclk(sclk), .sampleIn(sampleIn),
    .sdataOut(sdataOut), .sdataEn(sdataEn), .tracking(tracking),
    .modeNormal(modeNormal), .resultValid(resultValid)
  );

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic csLow();  csN = 1'b0; waitN(8); endtask
  task automatic csHigh(); csN = 1'b1; waitN(8); endtask
  task automatic fallE();  sclk = 1'b0; waitN(8); endtask
  task automatic riseE();  sclk = 1'b1; waitN(8); endtask
  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin fallE(); riseE(); end
  endtask

  function automatic int expBit(input logic [11:0] s, input int k);
    if (k < 3 || k > 14) return 0;
    return int'(s[14-k]);
  endfunction

  // R2 R3 R4 R5 R9: complete normal frame
  task automatic fullFrame(input logic [11:0] s);
    sampleIn = s;
    csLow();
    sampleIn = ~s; // R4: later changes must not matter
    check("R2 enable", sdataEn, 1);
    check("R2 hold", tracking, 0);
    check("R9 valid normal", resultValid, 1);
    check("R4 bit0", sdataOut, 0);
    for (int k = 1; k <= 16; k++) begin
      fallE();
      if (k < 16) check($sformatf("R4 bit%0d", k), sdataOut, expBit(s, k));
      else        check("R5 off at 16th", sdataEn, 0);
      riseE();
      if (k == 12) check("R3 hold at 12th rise", tracking, 0);
      if (k == 13) check("R3 track at 13th rise", tracking, 1);
    end
    pulses(3);
    check("R5 stays off", sdataEn, 0);
    check("R5 data low", sdataOut, 0);
    csHigh();
    check("R8 normal kept", modeNormal, 1);
  endtask

  task automatic earlyRise(); // R6
    csLow();
    pulses(1);
    csHigh();
    check("R6 off", sdataEn, 0);
    check("R6 mode unchanged", modeNormal, 1);
  endtask

  task automatic truncate(); // R8
    sampleIn = 12'h3C3;
    csLow();
    pulses(12);
    check("R8 still driving", sdataEn, 1);
    csHigh();
    check("R8 off", sdataEn, 0);
    check("R8 normal", modeNormal, 1);
  endtask

  task automatic shutAndWake(); // R7 R9 R10
    csLow();
    pulses(5);
    csHigh();
    check("R7 shutdown", modeNormal, 0);
    check("R7 off", sdataEn, 0);
    csLow();
    check("R9 wake frame invalid", resultValid, 0);
    check("R9 wake frame drives", sdataEn, 1);
    pulses(4);
    csHigh();
    check("R10 back to shutdown", modeNormal, 0);
    sampleIn = 12'h5A5;
    csLow();
    check("R9 dummy again", resultValid, 0);
    pulses(16);
    check("R9 awake after 10th", modeNormal, 1);
    csHigh();
    fullFrame(12'h5A5);
  endtask

  task automatic coincident(); // R11
    csLow();
    pulses(9);
    sclk = 1'b0; csN = 1'b1; waitN(8);
    sclk = 1'b1; waitN(8);
    check("R11 10th fall counted, normal", modeNormal, 1);
    csLow();
    pulses(1);
    sclk = 1'b0; csN = 1'b1; waitN(8);
    sclk = 1'b1; waitN(8);
    check("R11 2nd fall counted, shutdown", modeNormal, 0);
    csLow();
    check("R11 next frame invalid", resultValid, 0);
    pulses(16);
    csHigh();
    check("R11 restored", modeNormal, 1);
  endtask

  initial begin
    waitN(4);
    rst = 1'b0;
    waitN(2);
    check("R1 enable", sdataEn, 0);
    check("R1 data", sdataOut, 0);
    check("R1 tracking", tracking, 1);
    check("R1 valid", resultValid, 0);
    check("R1 mode", modeNormal, 1);
    fullFrame(12'hA5C);
    fullFrame(12'hFFF);
    fullFrame(12'h001);
    earlyRise();
    truncate();
    shutAndWake();
    coincident();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1_000_000;
    compared++;
    mismatched++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule